// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block sequences a small controller between three operating modes: normal, idle and full power-down. Software raises a one-cycle request for idle or power-down. The block then drives the clock enables for the core, the peripherals, the clock generator, the oscillator and the interval timer. It also drives a high-impedance enable for the analog output pins. The block runs on the always-on oscillator clock. Every enable is decoded from registered state, so the enables change only on that clock's edges.

While the block is in a low-power mode, it watches three wake sources: the interval-timer interrupt, the serial-port interrupt and an active-low external interrupt line. Each source is qualified by its own enable for the current mode. When several qualify together, one is chosen by a fixed priority, and its code is kept in a cause register. A wake passes through a single-cycle restart state before the core clock comes back. The asynchronous reset also ends any mode; it restores the defaults and reports reset as the cause.

The external line must stay high around entry into power-down. If the line is seen low shortly before or during the entry window, the block aborts the entry, remains in normal mode and raises a violation pulse.

Top module: `pmc_top`

## Requirements
- R1: While `rst_ni` is low, from any mode, the block is in normal mode (`mode_o`=0) with all five clock enables high, `ana_hiz_o` low, `wake_cause_o`=00 (reset) and `pd_viol_o` low.
- R2: In normal mode, an `idle_req_i` moves the block to idle (`mode_o`=1) at the next edge. In idle the core clock enable is low, the peripheral, clock-generator, oscillator and timer enables are high, and `ana_hiz_o` is low.
- R3: Idle ends only on a source whose `irq_en_i` bit is set: bit 0 is the timer, bit 1 is the serial port, bit 2 is the external line being low. A source whose bit is clear has no effect.
- R4: In normal mode, a `pd_req_i` enters the arm state (`mode_o`=2) for GUARD_CYC cycles and then power-down (`mode_o`=3). In the arm state the core clock enable is low and the other enables are high. When both requests come together, power-down wins.
- R5: In power-down the core, peripheral and clock-generator enables are low and `ana_hiz_o` is high. `osc_en_o` is the inverse of `osc_pd_i`, and `tic_clk_en_o` equals `tic_keep_i`. Both bits are captured when the request is accepted.
- R6: Power-down ends on the timer interrupt only if the timer was kept alive. It ends on the serial interrupt only with `ser_pd_wake_en_i` set, and on the external line low only with `ext_pd_wake_en_i` set. Other sources are ignored.
- R7: A qualified wake moves the block to the restart state (`mode_o`=4) for exactly one cycle. In that state the core enable is low and the peripheral, clock-generator, oscillator and timer enables are high. Normal mode follows.
- R8: Simultaneous wakes are resolved timer first, then serial, then external. The chosen cause is reported on `wake_cause_o` as 01 (timer), 10 (serial) or 11 (external), and it holds until the next wake.
- R9: A power-down request is refused if the external line is low at the request edge or at any of the previous GUARD_CYC edges. If the line goes low during the arm state, the entry is aborted. In both cases the block is in normal mode after the edge, and `pd_viol_o` is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| idle_req_i | input | 1 | Idle request pulse |
| pd_req_i | input | 1 | Power-down request pulse |
| osc_pd_i | input | 1 | Stop oscillator in power-down |
| tic_keep_i | input | 1 | Keep interval-timer clock in power-down |
| ser_pd_wake_en_i | input | 1 | Serial interrupt may end power-down |
| ext_pd_wake_en_i | input | 1 | External line may end power-down |
| irq_en_i | input | 3 | Idle wake enables (timer, serial, external) |
| tic_irq_i | input | 1 | Interval-timer interrupt |
| ser_irq_i | input | 1 | Serial-port interrupt |
| ext_irq_ni | input | 1 | External interrupt line, active low |
| mode_o | output | 3 | Current mode code |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| clkgen_en_o | output | 1 | Clock generator enable |
| osc_en_o | output | 1 | Oscillator enable |
| tic_clk_en_o | output | 1 | Interval-timer clock enable |
| ana_hiz_o | output | 1 | Analog outputs high impedance |
| wake_cause_o | output | 2 | Last wake cause |
| pd_viol_o | output | 1 | Power-down entry violation pulse |

## Verification
The assertions assume that every input is synchronous to `clk_i`. They also assume that the request inputs are pulses that software raises only in normal mode, and that the configuration bits are steady whenever a power-down request is accepted. The stimulus changes inputs only on falling edges. It sets the configuration bits before each request and drops each request after one cycle. It leaves a clean gap on the external line before each entry that is meant to succeed.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_IDLE   = 3'd1,
    MODE_ARM    = 3'd2,
    MODE_PD     = 3'd3,
    MODE_WAKE   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    CAUSE_RESET = 2'b00,
    CAUSE_TIC   = 2'b01,
    CAUSE_SER   = 2'b10,
    CAUSE_EXT   = 2'b11
  } cause_e;

  localparam int unsigned N_SRC = 3;
endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual
  import pmc_pkg::*;
(
  input  mode_e              mode_i,
  input  logic [N_SRC-1:0]   src_i,
  input  logic [N_SRC-1:0]   idle_en_i,
  input  logic [N_SRC-1:0]   pd_en_i,
  output logic               wake_o,
  output cause_e             cause_o
);
  logic [N_SRC-1:0] qual;

  always_comb begin
    unique case (mode_i)
      MODE_IDLE: qual = src_i & idle_en_i;
      MODE_PD:   qual = src_i & pd_en_i;
      default:   qual = '0;
    endcase
  end

  // lowest index wins
  always_comb begin
    cause_o = CAUSE_RESET;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (qual[i]) cause_o = cause_e'(i + 1);
    end
  end

  assign wake_o = |qual;
endmodule

// File: rtl/pmc_entry_guard.sv
module pmc_entry_guard #(
  parameter int unsigned GUARD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_irq_ni,
  output logic ext_low_o,
  output logic recent_low_o
);
  logic [GUARD_CYC-1:0] hist_q;

  assign ext_low_o = ~ext_irq_ni;

  generate
    if (GUARD_CYC == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= ext_low_o;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= {hist_q[GUARD_CYC-2:0], ext_low_o};
      end
    end
  endgenerate

  assign recent_low_o = ext_low_o | (|hist_q);
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pmc_pkg::*;
(
  input  mode_e mode_i,
  input  logic  osc_pd_i,
  input  logic  tic_keep_i,
  output logic  core_en_o,
  output logic  periph_en_o,
  output logic  clkgen_en_o,
  output logic  osc_en_o,
  output logic  tic_en_o,
  output logic  ana_hiz_o
);
  always_comb begin
    core_en_o   = 1'b0;
    periph_en_o = 1'b1;
    clkgen_en_o = 1'b1;
    osc_en_o    = 1'b1;
    tic_en_o    = 1'b1;
    ana_hiz_o   = 1'b0;
    unique case (mode_i)
      MODE_NORMAL: core_en_o = 1'b1;
      MODE_PD: begin
        periph_en_o = 1'b0;
        clkgen_en_o = 1'b0;
        osc_en_o    = ~osc_pd_i;
        tic_en_o    = tic_keep_i;
        ana_hiz_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int unsigned GUARD_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_req_i,
  input  logic       pd_req_i,
  input  logic       osc_pd_i,
  input  logic       tic_keep_i,
  input  logic       ser_pd_wake_en_i,
  input  logic       ext_pd_wake_en_i,
  input  logic [2:0] irq_en_i,
  input  logic       tic_irq_i,
  input  logic       ser_irq_i,
  input  logic       ext_irq_ni,
  output logic [2:0] mode_o,
  output logic       core_clk_en_o,
  output logic       periph_clk_en_o,
  output logic       clkgen_en_o,
  output logic       osc_en_o,
  output logic       tic_clk_en_o,
  output logic       ana_hiz_o,
  output logic [1:0] wake_cause_o,
  output logic       pd_viol_o
);
  localparam int unsigned CNT_W = (GUARD_CYC > 1) ? $clog2(GUARD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(GUARD_CYC - 1);

  mode_e            mode_q;
  cause_e           cause_q, wake_cause;
  logic [CNT_W-1:0] cnt_q;
  logic             viol_q, osc_pd_q, tic_keep_q;
  logic             ext_low, recent_low, wake;

  pmc_entry_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_irq_ni   (ext_irq_ni),
    .ext_low_o    (ext_low),
    .recent_low_o (recent_low)
  );

  pmc_wake_qual u_qual (
    .mode_i    (mode_q),
    .src_i     ({ext_low, ser_irq_i, tic_irq_i}),
    .idle_en_i (irq_en_i),
    .pd_en_i   ({ext_pd_wake_en_i, ser_pd_wake_en_i, tic_keep_q}),
    .wake_o    (wake),
    .cause_o   (wake_cause)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_NORMAL;
      cause_q    <= CAUSE_RESET;
      cnt_q      <= '0;
      viol_q     <= 1'b0;
      osc_pd_q   <= 1'b0;
      tic_keep_q <= 1'b1;
    end else begin
      viol_q <= 1'b0;
      unique case (mode_q)
        MODE_NORMAL: begin
          if (pd_req_i) begin
            if (recent_low) begin
              viol_q <= 1'b1;
            end else begin
              mode_q     <= MODE_ARM;
              cnt_q      <= CNT_LOAD;
              osc_pd_q   <= osc_pd_i;
              tic_keep_q <= tic_keep_i;
            end
          end else if (idle_req_i) begin
            mode_q <= MODE_IDLE;
          end
        end
        MODE_ARM: begin
          if (ext_low) begin
            mode_q <= MODE_NORMAL;
            viol_q <= 1'b1;
          end else if (cnt_q == '0) begin
            mode_q <= MODE_PD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        MODE_IDLE, MODE_PD: begin
          if (wake) begin
            mode_q  <= MODE_WAKE;
            cause_q <= wake_cause;
          end
        end
        default: mode_q <= MODE_NORMAL;
      endcase
    end
  end

  pmc_clk_gate u_gate (
    .mode_i      (mode_q),
    .osc_pd_i    (osc_pd_q),
    .tic_keep_i  (tic_keep_q),
    .core_en_o   (core_clk_en_o),
    .periph_en_o (periph_clk_en_o),
    .clkgen_en_o (clkgen_en_o),
    .osc_en_o    (osc_en_o),
    .tic_en_o    (tic_clk_en_o),
    .ana_hiz_o   (ana_hiz_o)
  );

  assign mode_o       = mode_q;
  assign wake_cause_o = cause_q;
  assign pd_viol_o    = viol_q;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tic_irq_i,
  input logic       ser_irq_i,
  input logic       ext_irq_ni,
  input logic       ser_pd_wake_en_i,
  input logic [2:0] mode_o,
  input logic       core_clk_en_o,
  input logic       periph_clk_en_o,
  input logic       clkgen_en_o,
  input logic       ana_hiz_o,
  input logic [1:0] wake_cause_o,
  input logic       pd_viol_o
);
  // R1
  core_only_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_clk_en_o |-> (mode_o == 3'd0));

  // R5
  pd_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3) |-> (!core_clk_en_o && !periph_clk_en_o && !clkgen_en_o && ana_hiz_o));

  // R4
  pd_via_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'd3) && ($past(mode_o) != 3'd3)) |-> ($past(mode_o) == 3'd2));

  // R6
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'd3) && !tic_irq_i && ext_irq_ni && !(ser_irq_i && ser_pd_wake_en_i))
      |=> (mode_o == 3'd3));

  // R7
  wake_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |=> (mode_o == 3'd0));

  // R8
  cause_on_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wake_cause_o) |-> (mode_o == 3'd4));

  // R9
  viol_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_viol_o |-> ((mode_o == 3'd0) && $past(mode_o) inside {3'd0, 3'd2}));
endmodule

bind pmc_top pmc_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .tic_irq_i        (tic_irq_i),
  .ser_irq_i        (ser_irq_i),
  .ext_irq_ni       (ext_irq_ni),
  .ser_pd_wake_en_i (ser_pd_wake_en_i),
  .mode_o           (mode_o),
  .core_clk_en_o    (core_clk_en_o),
  .periph_clk_en_o  (periph_clk_en_o),
  .clkgen_en_o      (clkgen_en_o),
  .ana_hiz_o        (ana_hiz_o),
  .wake_cause_o     (wake_cause_o),
  .pd_viol_o        (pd_viol_o)
);

// File: tb/tb_pmc_top.sv
module tb_pmc_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       idle_req_i = 1'b0, pd_req_i = 1'b0;
  logic       osc_pd_i = 1'b0, tic_keep_i = 1'b1;
  logic       ser_pd_wake_en_i = 1'b0, ext_pd_wake_en_i = 1'b0;
  logic [2:0] irq_en_i = 3'b000;
  logic       tic_irq_i = 1'b0, ser_irq_i = 1'b0, ext_irq_ni = 1'b1;
  logic [2:0] mode_o;
  logic       core_clk_en_o, periph_clk_en_o, clkgen_en_o, osc_en_o, tic_clk_en_o, ana_hiz_o;
  logic [1:0] wake_cause_o;
  logic       pd_viol_o;

  pmc_top dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    string      tag;
    logic [2:0] mode;
    logic [5:0] en;
    logic [1:0] cause;
    logic       viol;
  } item_t;

  item_t q[$];
  int n_vec = 0, n_bad = 0;
  logic cfg_osc_pd = 1'b0, cfg_tic_keep = 1'b1;
  logic mon_done = 1'b0;

  // {core, periph, clkgen, osc, tic, hiz} from R2, R4, R5, R7
  function automatic logic [5:0] exp_en(logic [2:0] m);
    case (m)
      3'd0:    return 6'b111110;
      3'd3:    return {3'b000, ~cfg_osc_pd, cfg_tic_keep, 1'b1};
      default: return 6'b011110;
    endcase
  endfunction

  function automatic logic [5:0] act_en();
    return {core_clk_en_o, periph_clk_en_o, clkgen_en_o, osc_en_o, tic_clk_en_o, ana_hiz_o};
  endfunction

  task automatic compare(item_t it);
    n_vec++;
    if (mode_o !== it.mode || act_en() !== it.en || wake_cause_o !== it.cause || pd_viol_o !== it.viol) begin
      n_bad++;
      $display("FAIL %s: mode=%0d en=%b cause=%b viol=%b expected mode=%0d en=%b cause=%b viol=%b",
               it.tag, mode_o, act_en(), wake_cause_o, pd_viol_o, it.mode, it.en, it.cause, it.viol);
    end
  endtask

  // driver: inputs already set at the falling edge, expectation for the next rising edge
  task automatic push(string tag, logic [2:0] m, logic [1:0] c, logic v);
    item_t it;
    it.tag = tag; it.mode = m; it.en = exp_en(m); it.cause = c; it.viol = v;
    q.push_back(it);
    @(negedge clk_i);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    int cyc = 0;
    while (!mon_done && cyc < 5000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!mon_done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected < 5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    item_t it;
    #1;
    it.tag = "R1 reset state"; it.mode = 3'd0; it.en = 6'b111110; it.cause = 2'b00; it.viol = 1'b0;
    compare(it);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // idle entry and wake
    idle_req_i = 1'b1;                      push("R2 idle entry", 3'd1, 2'b00, 1'b0);
    idle_req_i = 1'b0; ser_irq_i = 1'b1;    push("R3 masked serial ignored", 3'd1, 2'b00, 1'b0);
    irq_en_i = 3'b010;                      push("R3 enabled serial wakes idle", 3'd4, 2'b10, 1'b0);
    ser_irq_i = 1'b0;                       push("R7 restart then normal", 3'd0, 2'b10, 1'b0);
    idle_req_i = 1'b1; irq_en_i = 3'b101;   push("R2 idle again", 3'd1, 2'b10, 1'b0);
    idle_req_i = 1'b0; ext_irq_ni = 1'b0; tic_irq_i = 1'b1;
                                            push("R8 idle timer beats external", 3'd4, 2'b01, 1'b0);
    ext_irq_ni = 1'b1; tic_irq_i = 1'b0;    push("R7 back to normal", 3'd0, 2'b01, 1'b0);
    push("R9 quiet gap", 3'd0, 2'b01, 1'b0);
    push("R9 quiet gap", 3'd0, 2'b01, 1'b0);

    // power-down, oscillator stopped, timer kept; pd wins over idle
    osc_pd_i = 1'b1; tic_keep_i = 1'b1; cfg_osc_pd = 1'b1; cfg_tic_keep = 1'b1;
    irq_en_i = 3'b010;
    pd_req_i = 1'b1; idle_req_i = 1'b1;     push("R4 pd over idle, arm", 3'd2, 2'b01, 1'b0);
    pd_req_i = 1'b0; idle_req_i = 1'b0;     push("R4 arm second cycle", 3'd2, 2'b01, 1'b0);
    push("R5 power-down outputs", 3'd3, 2'b01, 1'b0);
    ser_irq_i = 1'b1;                       push("R6 serial without pd enable ignored", 3'd3, 2'b01, 1'b0);
    ser_pd_wake_en_i = 1'b1; tic_irq_i = 1'b1;
                                            push("R8 timer beats serial in pd", 3'd4, 2'b01, 1'b0);
    ser_irq_i = 1'b0; tic_irq_i = 1'b0;     push("R7 normal after pd wake", 3'd0, 2'b01, 1'b0);

    // power-down, oscillator running, timer stopped, serial wake
    osc_pd_i = 1'b0; tic_keep_i = 1'b0; cfg_osc_pd = 1'b0; cfg_tic_keep = 1'b0;
    ext_pd_wake_en_i = 1'b1;
    pd_req_i = 1'b1;                        push("R4 arm", 3'd2, 2'b01, 1'b0);
    pd_req_i = 1'b0;                        push("R4 arm", 3'd2, 2'b01, 1'b0);
    push("R5 pd timer clock off", 3'd3, 2'b01, 1'b0);
    tic_irq_i = 1'b1;                       push("R6 timer ignored when not kept", 3'd3, 2'b01, 1'b0);
    tic_irq_i = 1'b0; ser_irq_i = 1'b1;     push("R6 serial with pd enable wakes", 3'd4, 2'b10, 1'b0);
    ser_irq_i = 1'b0;                       push("R7 normal", 3'd0, 2'b10, 1'b0);
    push("R9 quiet gap", 3'd0, 2'b10, 1'b0);
    push("R9 quiet gap", 3'd0, 2'b10, 1'b0);

    // external wake from pd
    pd_req_i = 1'b1;                        push("R4 arm", 3'd2, 2'b10, 1'b0);
    pd_req_i = 1'b0;                        push("R4 arm", 3'd2, 2'b10, 1'b0);
    push("R5 pd", 3'd3, 2'b10, 1'b0);
    ext_irq_ni = 1'b0;                      push("R6 external with pd enable wakes", 3'd4, 2'b11, 1'b0);
    ext_irq_ni = 1'b1;                      push("R7 normal", 3'd0, 2'b11, 1'b0);

    // violations
    pd_req_i = 1'b1;                        push("R9 recent low refuses entry", 3'd0, 2'b11, 1'b1);
    pd_req_i = 1'b0;                        push("R9 violation is a pulse", 3'd0, 2'b11, 1'b0);
    pd_req_i = 1'b1;                        push("R4 clean entry", 3'd2, 2'b11, 1'b0);
    pd_req_i = 1'b0; ext_irq_ni = 1'b0;     push("R9 low during arm aborts", 3'd0, 2'b11, 1'b1);
    ext_irq_ni = 1'b1;                      push("R9 pulse ends", 3'd0, 2'b11, 1'b0);
    push("R9 quiet gap", 3'd0, 2'b11, 1'b0);
    push("R9 quiet gap", 3'd0, 2'b11, 1'b0);

    // reset ends power-down
    cfg_osc_pd = 1'b1; osc_pd_i = 1'b1;
    pd_req_i = 1'b1;                        push("R4 arm", 3'd2, 2'b11, 1'b0);
    pd_req_i = 1'b0;                        push("R4 arm", 3'd2, 2'b11, 1'b0);
    push("R5 pd before reset", 3'd3, 2'b11, 1'b0);
    rst_ni = 1'b0;
    #1;
    it.tag = "R1 reset ends power-down"; it.mode = 3'd0; it.en = 6'b111110; it.cause = 2'b00; it.viol = 1'b0;
    compare(it);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    wait (q.size() == 0);
    @(negedge clk_i);
    mon_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule